// File: doc/BRIEF.md
# External Window Access Bridge

The bridge sits between a simple CPU request port and a small set of register or memory windows that are implemented outside the register block. Each window occupies a fixed address range given by a base and a size. Every CPU request is compared against all ranges. A request that lands in a range goes out on that window's port, with the address made local to the window. A request that lands in no range goes to the internal register logic on a single strobe.

Only one external access may be in flight at a time. A two-state tracker (`TRK_IDLE`, `TRK_WAIT`) records whether an external access is outstanding. While it is in `TRK_WAIT`, the CPU side is stalled for reads and writes alike, and any request it presents is masked. The tracker moves `TRK_IDLE -> TRK_WAIT` when a request is issued to a window and no window acknowledge arrives in that cycle. It moves `TRK_WAIT -> TRK_IDLE` on any write or read acknowledge from a window.

Acknowledges from the windows are merged with internal completions into one write acknowledge and one read acknowledge. Read data is merged the same way. An optional register stage can be placed on all outputs toward the windows.

Top module: `ewb_bridge`

## Requirements
- R1: A request that is not stalled selects window i when base_i <= address <= base_i + size_i - 1. In that case `loc_req` stays low. When the address falls in no window, `loc_req` is high and every `win_req` bit stays low.
- R2: The local address of window i is address - base_i. It is carried in the low ceil(log2(size_i)) bits of that window's `LAW`-bit slice of `win_addr`, and the bits above are zero.
- R3: The selected window receives the direction (`win_we`, 1 = write), the write data and the bit enables, each in its own slice. At most one `win_req` bit is high in any cycle.
- R4: The tracker resets to `TRK_IDLE` and enters `TRK_WAIT` after an external request with no same-cycle window acknowledge. It returns to `TRK_IDLE` after any window acknowledge. `cpu_stall_rd` and `cpu_stall_wr` are both high exactly in `TRK_WAIT`.
- R5: A request presented in `TRK_WAIT` is masked. It raises no `win_req`, no `loc_req` and no CPU acknowledge.
- R6: `cpu_wr_ack` is the OR of every window write acknowledge and an unmasked write that hit no window. `cpu_wr_err` is always 0.
- R7: `cpu_rd_ack` is the OR of every window read acknowledge and an unmasked read that hit no window.
- R8: `cpu_rd_data` is the OR of `loc_rd_data`, taken only for an internal read completion, and each window's read data, taken only while that window's read acknowledge is high. With no read acknowledge, it is zero.
- R9: For a window whose read width is below the bus width (window 2 by default, 8 bits), the read data bits above that width are returned as zero.
- R10: With `RETIME` set, every window output is registered: it appears one cycle after the request and resets to zero.
- R11: After a request has been issued to a window, no further request reaches any window until an acknowledge has been returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | CPU request valid |
| cpu_wr | input | 1 | CPU request is a write |
| cpu_addr | input | AW | CPU byte address |
| cpu_wdata | input | DW | CPU write data |
| cpu_biten | input | DW | CPU write bit enables |
| cpu_stall_rd | output | 1 | Read requests are stalled |
| cpu_stall_wr | output | 1 | Write requests are stalled |
| cpu_wr_ack | output | 1 | Write completed |
| cpu_wr_err | output | 1 | Write error, always zero |
| cpu_rd_ack | output | 1 | Read completed |
| cpu_rd_data | output | DW | Read data |
| loc_req | output | 1 | Strobe to internal registers |
| loc_rd_data | input | DW | Internal read data for the current address |
| win_req | output | NWIN | Per-window request |
| win_we | output | NWIN | Per-window write direction |
| win_addr | output | NWIN*LAW | Per-window local address slices |
| win_wdata | output | NWIN*DW | Per-window write data slices |
| win_biten | output | NWIN*DW | Per-window bit-enable slices |
| win_rd_ack | input | NWIN | Per-window read acknowledge |
| win_rd_data | input | NWIN*DW | Per-window read data slices |
| win_wr_ack | input | NWIN | Per-window write acknowledge |

## Verification
The bound checker covers the cycle-level rules on every cycle:
- the tracker entering, holding and leaving `TRK_WAIT` in step with the window acknowledges;
- masking while stalled;
- the one-hot window request;
- zero read data without a read acknowledge;
- the constant write error.

Local address arithmetic, the choice of window at each range edge, narrow-window truncation and the one-cycle lag of the registered variant depend on the configured ranges. Only the bench's sweep over every address shows these. It reads and writes each address with acknowledge delays from zero to three cycles and probes with a second request while an access is in flight.

// File: rtl/ewb_pkg.sv
package ewb_pkg;

    // Outstanding-access tracker states.
    typedef enum logic [0:0] {
        TRK_IDLE = 1'b0,
        TRK_WAIT = 1'b1
    } trk_state_e;

    // Bits needed to express (size - 1), never less than one.
    function automatic int addr_bits(input logic [31:0] size);
        if (size <= 32'd2) return 1;
        return $clog2(size);
    endfunction

    // Widest local address over up to eight packed 32-bit sizes.
    function automatic int max_addr_bits(input logic [255:0] sizes, input int n);
        int best;
        best = 1;
        for (int i = 0; i < 8; i++) begin
            if (i < n) begin
                int b;
                b = addr_bits(sizes[i*32 +: 32]);
                if (b > best) best = b;
            end
        end
        return best;
    endfunction

endpackage

// File: rtl/ewb_decode.sv
module ewb_decode #(
    parameter int NWIN = 3,
    parameter int AW   = 8,
    parameter int LAW  = 6,
    parameter logic [NWIN-1:0][31:0] WIN_BASE = {32'h80, 32'h40, 32'h20},
    parameter logic [NWIN-1:0][31:0] WIN_SIZE = {32'd48, 32'd32, 32'd16}
) (
    input  logic                           req_ok,
    input  logic [AW-1:0]                  cpu_addr,
    output logic [NWIN-1:0]                hit,
    output logic                           ext_hit,
    output logic [NWIN-1:0][LAW-1:0]       loc_addr
);

    logic [31:0]    addr32;
    logic [LAW-1:0] addr_low;

    assign addr32   = 32'(cpu_addr);
    assign addr_low = LAW'(cpu_addr);

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        localparam logic [31:0]    BASE = WIN_BASE[g];
        localparam logic [31:0]    LAST = WIN_BASE[g] + WIN_SIZE[g] - 32'd1;
        localparam int             WB   = ewb_pkg::addr_bits(WIN_SIZE[g]);
        localparam logic [LAW-1:0] MASK = LAW'((64'd1 << WB) - 64'd1);

        // Inclusive range compare against the window bounds.
        assign hit[g] = req_ok && (addr32 >= BASE) && (addr32 <= LAST);

        // Bases are aligned to the power-of-two size, so the low bits are the offset.
        assign loc_addr[g] = addr_low & MASK;
    end

    assign ext_hit = |hit;

endmodule

// File: rtl/ewb_tracker.sv
module ewb_tracker
    import ewb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic issue,
    input  logic ack,
    output logic busy
);

    trk_state_e st_q;
    trk_state_e st_nxt;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TRK_IDLE;
        else        st_q <= st_nxt;
    end

    // Transitions: IDLE->WAIT on an unacknowledged issue, WAIT->IDLE on any ack.
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            TRK_IDLE: if (issue && !ack) st_nxt = TRK_WAIT;
            TRK_WAIT: if (ack)           st_nxt = TRK_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        busy = 1'b0;
        unique case (st_q)
            TRK_IDLE: busy = 1'b0;
            TRK_WAIT: busy = 1'b1;
        endcase
    end

endmodule

// File: rtl/ewb_port.sv
module ewb_port #(
    parameter int LAW    = 6,
    parameter int DW     = 16,
    parameter bit RETIME = 1'b0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sel,
    input  logic           we,
    input  logic [LAW-1:0] la,
    input  logic [DW-1:0]  wd,
    input  logic [DW-1:0]  be,
    output logic           o_req,
    output logic           o_we,
    output logic [LAW-1:0] o_addr,
    output logic [DW-1:0]  o_wd,
    output logic [DW-1:0]  o_be
);

    if (RETIME) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                o_req  <= 1'b0;
                o_we   <= 1'b0;
                o_addr <= '0;
                o_wd   <= '0;
                o_be   <= '0;
            end else begin
                o_req  <= sel;
                o_we   <= we;
                o_addr <= la;
                o_wd   <= wd;
                o_be   <= be;
            end
        end
    end else begin : g_comb
        logic unused_clk;
        assign unused_clk = clk & rst_n;
        assign o_req  = sel;
        assign o_we   = we;
        assign o_addr = la;
        assign o_wd   = wd;
        assign o_be   = be;
    end

endmodule

// File: rtl/ewb_merge.sv
module ewb_merge #(
    parameter int NWIN = 3,
    parameter int DW   = 16,
    parameter logic [NWIN-1:0][31:0] WIN_RDW = {32'd8, 32'd16, 32'd16}
) (
    input  logic                     loc_rd_done,
    input  logic                     loc_wr_done,
    input  logic [DW-1:0]            loc_rd_data,
    input  logic [NWIN-1:0]          win_rd_ack,
    input  logic [NWIN-1:0]          win_wr_ack,
    input  logic [NWIN-1:0][DW-1:0]  win_rd_data,
    output logic                     cpu_rd_ack,
    output logic                     cpu_wr_ack,
    output logic                     any_ack,
    output logic [DW-1:0]            cpu_rd_data
);

    logic [NWIN:0][DW-1:0] part;

    for (genvar g = 0; g < NWIN; g++) begin : g_part
        localparam int          RW   = int'(WIN_RDW[g]);
        localparam logic [DW-1:0] KEEP = (RW >= DW) ? {DW{1'b1}}
                                                    : DW'((64'd1 << RW) - 64'd1);
        // Each window contributes only under its own read acknowledge.
        assign part[g] = win_rd_ack[g] ? (win_rd_data[g] & KEEP) : '0;
    end

    assign part[NWIN] = loc_rd_done ? loc_rd_data : '0;

    always_comb begin
        cpu_rd_data = '0;
        for (int i = 0; i <= NWIN; i++) cpu_rd_data = cpu_rd_data | part[i];
    end

    assign cpu_rd_ack = loc_rd_done | (|win_rd_ack);
    assign cpu_wr_ack = loc_wr_done | (|win_wr_ack);
    assign any_ack    = (|win_rd_ack) | (|win_wr_ack);

endmodule

// File: rtl/ewb_bridge.sv
module ewb_bridge #(
    parameter int NWIN = 3,
    parameter int AW   = 8,
    parameter int DW   = 16,
    parameter logic [NWIN-1:0][31:0] WIN_BASE = {32'h80, 32'h40, 32'h20},
    parameter logic [NWIN-1:0][31:0] WIN_SIZE = {32'd48, 32'd32, 32'd16},
    parameter logic [NWIN-1:0][31:0] WIN_RDW  = {32'd8, 32'd16, 32'd16},
    parameter bit RETIME = 1'b0,
    localparam int LAW = ewb_pkg::max_addr_bits(256'(WIN_SIZE), NWIN)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cpu_req,
    input  logic                 cpu_wr,
    input  logic [AW-1:0]        cpu_addr,
    input  logic [DW-1:0]        cpu_wdata,
    input  logic [DW-1:0]        cpu_biten,
    output logic                 cpu_stall_rd,
    output logic                 cpu_stall_wr,
    output logic                 cpu_wr_ack,
    output logic                 cpu_wr_err,
    output logic                 cpu_rd_ack,
    output logic [DW-1:0]        cpu_rd_data,
    output logic                 loc_req,
    input  logic [DW-1:0]        loc_rd_data,
    output logic [NWIN-1:0]      win_req,
    output logic [NWIN-1:0]      win_we,
    output logic [NWIN*LAW-1:0]  win_addr,
    output logic [NWIN*DW-1:0]   win_wdata,
    output logic [NWIN*DW-1:0]   win_biten,
    input  logic [NWIN-1:0]      win_rd_ack,
    input  logic [NWIN*DW-1:0]   win_rd_data,
    input  logic [NWIN-1:0]      win_wr_ack
);

    logic                       pending;
    logic                       req_ok;
    logic [NWIN-1:0]            hit;
    logic                       ext_hit;
    logic [NWIN-1:0][LAW-1:0]   loc_addr;
    logic                       any_ack;
    logic                       loc_rd_done;
    logic                       loc_wr_done;
    logic [NWIN-1:0][DW-1:0]    rd_slices;

    // Both directions stall while an external access is outstanding.
    assign req_ok       = cpu_req & ~pending;
    assign cpu_stall_rd = pending;
    assign cpu_stall_wr = pending;
    assign cpu_wr_err   = 1'b0;

    ewb_decode #(
        .NWIN(NWIN), .AW(AW), .LAW(LAW),
        .WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE)
    ) u_decode (
        .req_ok   (req_ok),
        .cpu_addr (cpu_addr),
        .hit      (hit),
        .ext_hit  (ext_hit),
        .loc_addr (loc_addr)
    );

    assign loc_req     = req_ok & ~ext_hit;
    assign loc_wr_done = loc_req & cpu_wr;
    assign loc_rd_done = loc_req & ~cpu_wr;

    ewb_tracker u_tracker (
        .clk   (clk),
        .rst_n (rst_n),
        .issue (ext_hit),
        .ack   (any_ack),
        .busy  (pending)
    );

    for (genvar g = 0; g < NWIN; g++) begin : g_port
        ewb_port #(.LAW(LAW), .DW(DW), .RETIME(RETIME)) u_port (
            .clk    (clk),
            .rst_n  (rst_n),
            .sel    (hit[g]),
            .we     (cpu_wr),
            .la     (loc_addr[g]),
            .wd     (cpu_wdata),
            .be     (cpu_biten),
            .o_req  (win_req[g]),
            .o_we   (win_we[g]),
            .o_addr (win_addr[g*LAW +: LAW]),
            .o_wd   (win_wdata[g*DW +: DW]),
            .o_be   (win_biten[g*DW +: DW])
        );
    end

    assign rd_slices = win_rd_data;

    ewb_merge #(.NWIN(NWIN), .DW(DW), .WIN_RDW(WIN_RDW)) u_merge (
        .loc_rd_done (loc_rd_done),
        .loc_wr_done (loc_wr_done),
        .loc_rd_data (loc_rd_data),
        .win_rd_ack  (win_rd_ack),
        .win_wr_ack  (win_wr_ack),
        .win_rd_data (rd_slices),
        .cpu_rd_ack  (cpu_rd_ack),
        .cpu_wr_ack  (cpu_wr_ack),
        .any_ack     (any_ack),
        .cpu_rd_data (cpu_rd_data)
    );

endmodule

// File: rtl/ewb_bridge_chk.sv
module ewb_bridge_chk #(
    parameter int NWIN   = 3,
    parameter int DW     = 16,
    parameter bit RETIME = 1'b0
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cpu_req,
    input logic            cpu_wr,
    input logic            cpu_stall_rd,
    input logic            cpu_stall_wr,
    input logic            cpu_wr_ack,
    input logic            cpu_wr_err,
    input logic            cpu_rd_ack,
    input logic [DW-1:0]   cpu_rd_data,
    input logic [NWIN-1:0] win_req,
    input logic [NWIN-1:0] win_rd_ack,
    input logic [NWIN-1:0] win_wr_ack,
    input logic            ext_hit
);

    logic acked;
    assign acked = (|win_rd_ack) | (|win_wr_ack);

    assert_enter_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_hit && !acked) |=> (cpu_stall_rd && cpu_stall_wr));

    assert_leave_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_stall_rd && acked) |=> (!cpu_stall_rd && !cpu_stall_wr));

    assert_hold_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_stall_rd && !acked) |=> cpu_stall_rd);

    assert_stall_masks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_stall_rd && !acked) |-> (!cpu_wr_ack && !cpu_rd_ack));

    assert_no_wr_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_wr_err);

    assert_rd_ack_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|win_rd_ack) && !(cpu_req && !cpu_wr)) |-> !cpu_rd_ack);

    assert_rd_data_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rd_ack |-> (cpu_rd_data == '0));

    assert_single_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win_req));

    if (RETIME) begin : g_rt
        assert_registered_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (|win_req) |-> $past(ext_hit));
    end else begin : g_cb
        assert_one_in_flight_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (|win_req) |-> !cpu_stall_rd);
    end

endmodule

bind ewb_bridge ewb_bridge_chk #(.NWIN(NWIN), .DW(DW), .RETIME(RETIME)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_req      (cpu_req),
    .cpu_wr       (cpu_wr),
    .cpu_stall_rd (cpu_stall_rd),
    .cpu_stall_wr (cpu_stall_wr),
    .cpu_wr_ack   (cpu_wr_ack),
    .cpu_wr_err   (cpu_wr_err),
    .cpu_rd_ack   (cpu_rd_ack),
    .cpu_rd_data  (cpu_rd_data),
    .win_req      (win_req),
    .win_rd_ack   (win_rd_ack),
    .win_wr_ack   (win_wr_ack),
    .ext_hit      (ext_hit)
);

// File: tb/ewb_bridge_test.sv
module ewb_bridge_test;

    localparam int NWIN = 3;
    localparam int AW   = 8;
    localparam int DW   = 16;
    localparam int LAW  = 6;

    int base_t [NWIN] = '{32'h20, 32'h40, 32'h80};
    int size_t [NWIN] = '{16, 32, 48};
    int rdw_t  [NWIN] = '{16, 16, 8};

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic                rst_n;
    logic                cpu_req, cpu_wr;
    logic [AW-1:0]       cpu_addr;
    logic [DW-1:0]       cpu_wdata, cpu_biten, loc_rd_data;
    logic [NWIN-1:0]     win_rd_ack, win_wr_ack;
    logic [NWIN*DW-1:0]  win_rd_data;

    logic                stall_rd, stall_wr, wr_ack, wr_err, rd_ack, loc_req;
    logic [DW-1:0]       rd_data;
    logic [NWIN-1:0]     win_req, win_we;
    logic [NWIN*LAW-1:0] win_addr;
    logic [NWIN*DW-1:0]  win_wdata, win_biten;

    logic                rt_stall_rd, rt_stall_wr, rt_wr_ack, rt_wr_err, rt_rd_ack, rt_loc_req;
    logic [DW-1:0]       rt_rd_data;
    logic [NWIN-1:0]     rt_req, rt_we;
    logic [NWIN*LAW-1:0] rt_addr;
    logic [NWIN*DW-1:0]  rt_wdata, rt_biten;

    ewb_bridge #(.RETIME(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_wr(cpu_wr),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_biten(cpu_biten),
        .cpu_stall_rd(stall_rd), .cpu_stall_wr(stall_wr), .cpu_wr_ack(wr_ack),
        .cpu_wr_err(wr_err), .cpu_rd_ack(rd_ack), .cpu_rd_data(rd_data),
        .loc_req(loc_req), .loc_rd_data(loc_rd_data),
        .win_req(win_req), .win_we(win_we), .win_addr(win_addr),
        .win_wdata(win_wdata), .win_biten(win_biten),
        .win_rd_ack(win_rd_ack), .win_rd_data(win_rd_data), .win_wr_ack(win_wr_ack)
    );

    // Registered variant; its windows never acknowledge.
    ewb_bridge #(.RETIME(1'b1)) uut_rt (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_wr(cpu_wr),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_biten(cpu_biten),
        .cpu_stall_rd(rt_stall_rd), .cpu_stall_wr(rt_stall_wr), .cpu_wr_ack(rt_wr_ack),
        .cpu_wr_err(rt_wr_err), .cpu_rd_ack(rt_rd_ack), .cpu_rd_data(rt_rd_data),
        .loc_req(rt_loc_req), .loc_rd_data(loc_rd_data),
        .win_req(rt_req), .win_we(rt_we), .win_addr(rt_addr),
        .win_wdata(rt_wdata), .win_biten(rt_biten),
        .win_rd_ack('0), .win_rd_data(win_rd_data), .win_wr_ack('0)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit rt_first = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int find_win(input int a);
        for (int i = 0; i < NWIN; i++)
            if (a >= base_t[i] && a <= base_t[i] + size_t[i] - 1) return i;
        return -1;
    endfunction

    function automatic logic [DW-1:0] rd_pat(input int i, input int a);
        return DW'((a * 37 + i * 4099) ^ 16'h5A5A);
    endfunction

    function automatic logic [DW-1:0] rd_mask(input int i);
        return (rdw_t[i] >= DW) ? {DW{1'b1}} : DW'((32'd1 << rdw_t[i]) - 1);
    endfunction

    task automatic access(input int a, input bit we, input int dly);
        int w;
        logic [DW-1:0] wd, be;
        w  = find_win(a);
        wd = DW'(a * 257 + 3);
        be = {8'(a), ~8'(a)};
        @(negedge clk);
        cpu_req = 1'b1; cpu_wr = we; cpu_addr = AW'(a);
        cpu_wdata = wd; cpu_biten = be;
        loc_rd_data = {~8'(a), 8'(a)};
        for (int i = 0; i < NWIN; i++) win_rd_data[i*DW +: DW] = rd_pat(i, a);
        #2;
        chk("R6 write error constant", 32'(wr_err), 0);
        if (w < 0) begin
            chk("R1 no window outside ranges", 32'(win_req), 0);
            chk("R1 internal strobe", 32'(loc_req), 1);
            if (we) begin
                chk("R6 internal write ack", 32'(wr_ack), 1);
            end else begin
                chk("R7 internal read ack", 32'(rd_ack), 1);
                chk("R8 internal read data", 32'(rd_data), 32'({~8'(a), 8'(a)}));
            end
            @(negedge clk);
            cpu_req = 1'b0;
            #2;
            chk("R4 no stall after internal access", 32'(stall_rd), 0);
        end else begin
            chk("R1 window select", 32'(win_req), 32'(1 << w));
            chk("R1 internal strobe off", 32'(loc_req), 0);
            chk("R2 local address", 32'(win_addr[w*LAW +: LAW]), 32'(a - base_t[w]));
            chk("R3 direction", 32'(win_we[w]), 32'(we));
            chk("R3 write data", 32'(win_wdata[w*DW +: DW]), 32'(wd));
            chk("R3 bit enables", 32'(win_biten[w*DW +: DW]), 32'(be));
            if (rt_first) chk("R10 registered lag", 32'(rt_req), 0);
            for (int k = 0; k <= dly; k++) begin
                if (k > 0) begin
                    @(negedge clk);
                    if (k == 1) begin
                        cpu_req  = 1'b1;
                        cpu_addr = AW'(base_t[(w + 1) % NWIN]);
                    end else begin
                        cpu_req = 1'b0;
                    end
                    #2;
                    chk("R4 stall while waiting", 32'({stall_rd, stall_wr}), 32'b11);
                    chk("R11 no second window request", 32'(win_req), 0);
                    chk("R5 masked internal strobe", 32'(loc_req), 0);
                    if (rt_first && k == 1) begin
                        chk("R10 registered request", 32'(rt_req), 32'(1 << w));
                        chk("R10 registered address", 32'(rt_addr[w*LAW +: LAW]), 32'(a - base_t[w]));
                        chk("R10 registered direction", 32'(rt_we[w]), 32'(we));
                        chk("R10 registered data", 32'(rt_wdata[w*DW +: DW]), 32'(wd));
                    end
                end
                if (k == dly) begin
                    if (we) win_wr_ack[w] = 1'b1;
                    else    win_rd_ack[w] = 1'b1;
                    #1;
                    if (we) begin
                        chk("R6 window write ack", 32'(wr_ack), 1);
                        chk("R7 no read ack on write", 32'(rd_ack), 0);
                    end else begin
                        chk("R7 window read ack", 32'(rd_ack), 1);
                        chk((rdw_t[w] < DW) ? "R9 narrow read data" : "R8 window read data",
                            32'(rd_data), 32'(rd_pat(w, a) & rd_mask(w)));
                    end
                end else begin
                    chk("R5 no ack before window", 32'({wr_ack, rd_ack}), 0);
                end
            end
            @(negedge clk);
            win_wr_ack = '0; win_rd_ack = '0; cpu_req = 1'b0;
            #2;
            chk("R4 stall released", 32'({stall_rd, stall_wr}), 0);
        end
    endtask

    initial begin
        rst_n = 1'b0; cpu_req = 1'b0; cpu_wr = 1'b0; cpu_addr = '0;
        cpu_wdata = '0; cpu_biten = '0; loc_rd_data = '0;
        win_rd_ack = '0; win_wr_ack = '0; win_rd_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10 reset request", 32'(rt_req), 0);
        chk("R10 reset address", 32'(rt_addr), 0);
        chk("R10 reset data", 32'(rt_wdata[31:0]), 0);
        chk("R4 reset stall", 32'({stall_rd, stall_wr}), 0);
        rst_n = 1'b1;
        #2;
        chk("R4 idle after reset", 32'({stall_rd, rt_stall_rd}), 0);
        chk("R8 idle read data", 32'(rd_data), 0);

        rt_first = 1'b1;
        access(32'h45, 1'b1, 2);
        rt_first = 1'b0;

        for (int a = 0; a < 256; a++) begin
            access(a, 1'b0, a % 4);
            access(a, 1'b1, (a + 1) % 4);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule